// File: doc/BRIEF.md
# Op-Queued Serial Flash Command Sequencer

This block is a register-driven SPI master that uses a single data line in each direction and serves serial NAND flash. Software builds each transaction as a list of queued operation words. Each word carries an opcode and a byte count. Payload bytes travel through a separate byte-wide data FIFO. An engine pops one operation at a time and does one of three things: it sets the chip-select level, it shifts bytes from the data FIFO out on `mosi`, or it shifts bytes in from `miso` and pushes them into the data FIFO.

A typical command sequence looks like this. Software asserts chip select, then sends the command byte, the address bytes and any dummy bytes as ordinary transmit operations. It then reads or writes the payload and releases chip select. Software polls the idle flag to learn that the queued work has finished. It reads received bytes one at a time: it reads the head byte, then writes a pop strobe to advance the FIFO.

Top module: `opq_spi_seq`

## Requirements
- R1: After reset, `cs_n` is 1 and `sck` is 0. The idle flag (address 0x3) reads 1 and the data-empty flag (address 0x6) reads 1. The op-full flag (address 0x2) reads 0 and the data-full flag (address 0x5) reads 0.
- R2: An op word holds the byte count in bits [8:0] and the opcode in bits [13:9]. Writing address 0x0 stores the word. Writing 1 in bit 0 to address 0x1 queues the stored word. The idle flag at address 0x3 reads 1 only when the op queue is empty and the engine has no operation in progress.
- R3: An operation with an opcode outside 0x00, 0x01, 0x08 and 0x0C is discarded without any serial activity. So is a transmit or receive operation with a byte count of 0.
- R4: Opcode 0x01 with a count of 1 drives `cs_n` low. Opcode 0x00 with a count of 1 drives `cs_n` high. A chip-select opcode with any other count leaves `cs_n` unchanged.
- R5: Opcode 0x08 sends the next count bytes from the data FIFO, MSB first, in SPI mode 0. `sck` idles low and each high phase lasts DIV/2 clocks. The engine waits while the data FIFO is empty.
- R6: Opcode 0x0C receives count bytes. The engine samples `miso` at each rising `sck` edge, MSB first, and pushes each byte into the data FIFO. It holds `mosi` at 0 and waits before a byte while the data FIFO is full.
- R7: Address 0x7 reads the head byte of the data FIFO. Reading it does not advance the FIFO. Writing 1 in bit 0 to address 0x8 pops the head byte. Writing address 0x4 pushes data bits [7:0].
- R8: Each FIFO holds DEPTH (16) entries. The full flags are at addresses 0x2 and 0x5. A push while full and a pop while empty are both ignored and change no stored entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 14 | Register write data |
| reg_rdata | output | 14 | Register read data (combinational) |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench acts as the flash. It captures `mosi` on each rising `sck` edge and plays back a known `miso` pattern. It measures every `sck` high phase, so a wrong bit order, a wrong sampling edge or a wrong clock divider shows up as corrupt bytes or a mismeasured pulse.

Several corner cases are targeted directly:
- It overfills both FIFOs. A design that accepts the extra push would hand back the wrong last byte, or send one byte too many.
- It pops an empty data FIFO and then pushes a byte. A design whose pointers slip on that pop would return stale data.
- It queues zero-length and unknown operations. A design that treats them as real transfers would toggle `sck`.
- It queues chip-select operations with the wrong count. A design that ignores the count check would move `cs_n`.

// File: rtl/opq_spi_seq.sv
module opq_spi_seq #(
  parameter int DEPTH = 16,
  parameter int DIV   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [13:0] reg_wdata,
  output logic [13:0] reg_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DIV / 2;
  localparam int PW   = (HALF > 1) ? $clog2(HALF) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} st_t;
  st_t st;

  wire sw_oword = reg_wr && reg_addr == 4'h0;
  wire sw_opush = reg_wr && reg_addr == 4'h1 && reg_wdata[0];
  wire sw_dwr   = reg_wr && reg_addr == 4'h4;
  wire sw_dpop  = reg_wr && reg_addr == 4'h8 && reg_wdata[0];

  // op queue
  logic [13:0]   oword_q;
  logic [13:0]   omem [DEPTH];
  logic [AW-1:0] owp, orp;
  logic [CW-1:0] ocnt;
  wire o_full  = ocnt == CW'(DEPTH);
  wire o_empty = ocnt == '0;
  wire o_push  = sw_opush && !o_full;
  wire o_pop   = st == S_IDLE && !o_empty;
  wire [13:0] ohead = omem[orp];
  wire [8:0]  olen  = ohead[8:0];
  wire [4:0]  opc   = ohead[13:9];

  always_ff @(posedge clk)
    if (o_push) omem[owp] <= oword_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oword_q <= '0; owp <= '0; orp <= '0; ocnt <= '0;
    end else begin
      if (sw_oword) oword_q <= reg_wdata;
      if (o_push) owp <= owp + 1'b1;
      if (o_pop)  orp <= orp + 1'b1;
      ocnt <= ocnt + CW'(o_push) - CW'(o_pop);
    end

  // data queue
  logic [7:0]    dmem [DEPTH];
  logic [AW-1:0] dwp, drp;
  logic [CW-1:0] dcnt;
  logic          is_rx;
  logic [8:0]    rem;
  logic [7:0]    sh;
  logic          rbit, sck_q, cs_q;
  logic [2:0]    bitn;
  logic [PW-1:0] ph;
  wire d_full  = dcnt == CW'(DEPTH);
  wire d_empty = dcnt == '0;
  wire [7:0] dhead = dmem[drp];
  wire ph_end  = ph == PW'(HALF - 1);
  wire byte_end = st == S_SHIFT && ph_end && sck_q && bitn == 3'd7;
  wire [7:0] rxbyte = {sh[6:0], rbit};
  wire e_dpop  = st == S_WAIT && !is_rx && !d_empty;
  wire e_dpush = byte_end && is_rx;
  wire d_push  = (e_dpush || sw_dwr) && !d_full;
  wire d_pop   = (e_dpop || sw_dpop) && !d_empty;
  wire [7:0] d_in = e_dpush ? rxbyte : reg_wdata[7:0];

  always_ff @(posedge clk)
    if (d_push) dmem[dwp] <= d_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dwp <= '0; drp <= '0; dcnt <= '0;
    end else begin
      if (d_push) dwp <= dwp + 1'b1;
      if (d_pop)  drp <= drp + 1'b1;
      dcnt <= dcnt + CW'(d_push) - CW'(d_pop);
    end

  // engine
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; is_rx <= 1'b0; rem <= '0; sh <= '0; rbit <= 1'b0;
      sck_q <= 1'b0; cs_q <= 1'b1; bitn <= '0; ph <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (!o_empty) begin
            if ((opc == 5'h08 || opc == 5'h0C) && olen != 9'd0) begin
              st    <= S_WAIT;
              is_rx <= opc == 5'h0C;
              rem   <= olen;
            end else if (opc[4:1] == 4'd0 && olen == 9'd1) begin
              cs_q <= !opc[0];
            end
          end
        S_WAIT:
          if (is_rx ? !d_full : !d_empty) begin
            sh    <= is_rx ? 8'h00 : dhead;
            st    <= S_SHIFT;
            ph    <= '0;
            bitn  <= '0;
            sck_q <= 1'b0;
          end
        default: begin
          if (ph_end) begin
            ph    <= '0;
            sck_q <= !sck_q;
            if (!sck_q) rbit <= miso;
            else begin
              sh <= rxbyte;
              if (bitn == 3'd7) begin
                rem <= rem - 9'd1;
                st  <= (rem == 9'd1) ? S_IDLE : S_WAIT;
              end else bitn <= bitn + 3'd1;
            end
          end else ph <= ph + 1'b1;
        end
      endcase
    end

  assign sck  = sck_q;
  assign cs_n = cs_q;
  assign mosi = st == S_SHIFT && sh[7];
  wire idle_flag = o_empty && st == S_IDLE;

  always_comb
    case (reg_addr)
      4'h0:    reg_rdata = oword_q;
      4'h2:    reg_rdata = {13'd0, o_full};
      4'h3:    reg_rdata = {13'd0, idle_flag};
      4'h5:    reg_rdata = {13'd0, d_full};
      4'h6:    reg_rdata = {13'd0, d_empty};
      4'h7:    reg_rdata = {6'd0, dhead};
      default: reg_rdata = '0;
    endcase

  a_r8_op_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ocnt <= CW'(DEPTH));
  a_r8_data_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= CW'(DEPTH));
  a_r8_op_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (o_full && sw_opush && !o_pop) |=> o_full);
  a_r2_idle_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sck);
  a_r5_mosi_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
  a_r4_cs_moves_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> $past(st) == S_IDLE);
endmodule

// File: tb/opq_spi_seq_tb.sv
`timescale 1ns/1ps
module opq_spi_seq_tb;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0, reg_wr = 0, miso;
  logic [3:0] reg_addr = 0;
  logic [13:0] reg_wdata = 0, reg_rdata;
  logic sck, mosi, cs_n;
  int errors = 0, checks = 0, cycles = 0;

  opq_spi_seq #(.DEPTH(16), .DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #4 clk = ~clk;

  // flash model
  logic [7:0] miso_arr [0:63];
  logic [7:0] got [$];
  logic [7:0] sreg = 0;
  int bitc = 0;
  logic [15:0] sidx = 0;
  assign miso = miso_arr[sidx[8:3]][3'd7 - sidx[2:0]];
  always @(posedge sck) begin
    sreg = {sreg[6:0], mosi};
    bitc++;
    if (bitc == 8) begin got.push_back(sreg); bitc = 0; end
  end
  always @(negedge sck) sidx <= sidx + 16'd1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock pulse-width model (R5)
  int hicnt = 0;
  always @(negedge clk) begin
    cycles++;
    if (sck) hicnt++;
    else if (hicnt != 0) begin
      check(hicnt == DIV/2, "R5 sck high phase", hicnt, DIV/2);
      hicnt = 0;
    end
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [13:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [13:0] v);
    @(negedge clk); reg_addr = a; reg_wr = 0; #1 v = reg_rdata;
  endtask
  task automatic push_op(input logic [4:0] op, input logic [8:0] len);
    wr(4'h0, {op, len}); wr(4'h1, 14'd1);
  endtask
  task automatic wait_idle();
    logic [13:0] v;
    for (int i = 0; i < 20000; i++) begin rd(4'h3, v); if (v[0]) break; end
  endtask

  initial begin
    logic [13:0] v;
    int base;
    for (int i = 0; i < 64; i++) miso_arr[i] = 8'h00;
    miso_arr[2] = 8'hC3; miso_arr[3] = 8'h5A; miso_arr[4] = 8'h81;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(4'h3, v); check(v == 1, "R1 idle flag", v, 1);
    rd(4'h2, v); check(v == 0, "R1 op full", v, 0);
    rd(4'h6, v); check(v == 1, "R1 data empty", v, 1);
    rd(4'h5, v); check(v == 0, "R1 data full", v, 0);
    check(cs_n == 1 && sck == 0, "R1 cs_n/sck", {cs_n, sck}, 2);
    // R4
    push_op(5'h01, 9'd1); wait_idle();
    check(cs_n == 0, "R4 cs assert", cs_n, 0);
    push_op(5'h00, 9'd2); wait_idle();
    check(cs_n == 0, "R4 cs op with count 2 ignored", cs_n, 0);
    // R5, R2
    wr(4'h4, 14'hA5); wr(4'h4, 14'h3C);
    push_op(5'h08, 9'd2);
    repeat (3) @(negedge clk);
    rd(4'h3, v); check(v == 0, "R2 idle flag low while busy", v, 0);
    wait_idle();
    check(got.size() == 2, "R5 byte count", got.size(), 2);
    if (got.size() >= 2) begin
      check(got[0] == 8'hA5, "R5 first byte MSB first", got[0], 8'hA5);
      check(got[1] == 8'h3C, "R5 second byte", got[1], 8'h3C);
    end
    rd(4'h6, v); check(v == 1, "R5 data fifo drained", v, 1);
    // R6, R7
    push_op(5'h0C, 9'd3); wait_idle();
    rd(4'h7, v); check(v == 14'hC3, "R6 rx byte 0", v, 14'hC3);
    rd(4'h7, v); check(v == 14'hC3, "R7 head read does not advance", v, 14'hC3);
    wr(4'h8, 14'd1);
    rd(4'h7, v); check(v == 14'h5A, "R6 rx byte 1", v, 14'h5A);
    wr(4'h8, 14'd1);
    rd(4'h7, v); check(v == 14'h81, "R6 rx byte 2", v, 14'h81);
    wr(4'h8, 14'd1);
    rd(4'h6, v); check(v == 1, "R7 empty after pops", v, 1);
    check(got.size() == 5 && got[4] == 8'h00, "R6 mosi low during rx", got.size(), 5);
    // R3
    base = got.size();
    push_op(5'h08, 9'd0); push_op(5'h05, 9'd3); push_op(5'h00, 9'd1);
    wait_idle();
    check(got.size() == base && bitc == 0, "R3 no serial activity", got.size(), base);
    check(cs_n == 1, "R4 cs release", cs_n, 1);
    // R8 data fifo
    for (int i = 0; i < 17; i++) wr(4'h4, 14'(8'h10 + i));
    rd(4'h5, v); check(v == 1, "R8 data full", v, 1);
    for (int i = 0; i < 16; i++) begin
      rd(4'h7, v); check(v == 14'(8'h10 + i), "R8 fifo order", v, 8'h10 + i);
      wr(4'h8, 14'd1);
    end
    rd(4'h6, v); check(v == 1, "R8 extra push dropped", v, 1);
    wr(4'h8, 14'd1);
    wr(4'h4, 14'h77);
    rd(4'h7, v); check(v == 14'h77, "R8 pop on empty ignored", v, 14'h77);
    wr(4'h8, 14'd1);
    // R8 op fifo
    base = got.size();
    for (int i = 0; i < 17; i++) push_op(5'h08, 9'd1);
    rd(4'h2, v); check(v == 1, "R8 op full", v, 1);
    push_op(5'h08, 9'd1);
    for (int i = 0; i < 18; i++) begin
      for (int k = 0; k < 5000; k++) begin rd(4'h5, v); if (!v[0]) break; end
      wr(4'h4, 14'(8'h40 + i));
    end
    wait_idle();
    check(got.size() == base + 17, "R8 op overflow ignored", got.size(), base + 17);
    if (got.size() == base + 17)
      check(got[base + 16] == 8'h50, "R8 last sent byte", got[base + 16], 8'h50);
    rd(4'h7, v); check(v == 14'h51, "R8 leftover byte", v, 14'h51);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule